// File: doc/BRIEF.md
# Dual-Clock Ping-Pong Pixel Line Buffer

This block holds scan-line pixels between a memory burst fetcher and a pixel output path. The fetcher side runs on the system clock and hands over one 32-bit word per acknowledged bus beat. The block keeps its own write column. The column is loaded at the start of a burst and steps by one word's worth of bytes on every accepted beat. The display side runs on an unrelated video clock. It presents a pixel column every cycle and gets back one 8-bit pixel two cycles later.

The storage is split into two halves. The low bit of the current display row picks the half that is shown, and writes always go to the other half. The next row is therefore fetched while the current one is being scanned out. Within each stored word the leftmost pixel sits in the most significant byte, so the read side reverses the byte lanes. Only the low 11 bits of a column take part in addressing.

Top module: `pixel_line_buffer`

## Requirements
- R1: A word is stored only on a `sys_clk` rising edge where `bus_active` and `bus_ack` are both 1. It goes to word slot `fetch_col[10:2]` of the half being filled.
- R2: The write column loads `burst_col` on a `sys_clk` edge with `burst_load` = 1, which takes priority. Otherwise it advances by 4 on every accepted beat and holds its value on all other edges.
- R3: With `row_odd` = 0, writes fill half 1 and reads come from half 0. With `row_odd` = 1, writes fill half 0 and reads come from half 1.
- R4: Byte lane k of a stored word is bits [8k+7:8k]. The pixel at column c is lane 3 - c[1:0] of word c[10:2], so column 4n reads bits [31:24] of word n.
- R5: Column bits above bit 10 are ignored on both the write column and `pix_col`.
- R6: `pix_out` shows the pixel for the `pix_col` and `row_odd` sampled two `vid_clk` rising edges earlier.
- R7: While `vid_rst_n` is low, `pix_out` clears to 0 on the next `vid_clk` edge. While `sys_rst_n` is low, the write column clears to 0 on the next `sys_clk` edge. Both resets are synchronous.
- R8: A cycle with `bus_active` = 1 and `bus_ack` = 0, or with `bus_active` = 0 and `bus_ack` = 1, neither writes nor moves the write column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Write-side (system) clock |
| sys_rst_n | input | 1 | Synchronous active-low reset, system domain |
| bus_active | input | 1 | Fetch bus cycle in progress |
| bus_ack | input | 1 | Beat acknowledge; a data word is valid |
| burst_load | input | 1 | Load the write column from `burst_col` |
| burst_col | input | 12 | Byte column at which a burst starts |
| wr_data | input | 32 | Fetched word, four pixels |
| row_odd | input | 1 | Low bit of the current display row |
| vid_clk | input | 1 | Read-side (video) clock |
| vid_rst_n | input | 1 | Synchronous active-low reset, video domain |
| pix_col | input | 12 | Pixel column to display |
| pix_out | output | 8 | Registered pixel |

## Verification
A wrong write column moves pixels sideways by whole words, and a missed beat shifts all the pixels that follow it. Either fault appears at `pix_out` as soon as the affected half is scanned, two video clocks after the first affected column is presented. A fault in half selection or lane order damages the shown row or the row being fetched. The half left alone is therefore swept as well as the half just written. A one-cycle latency error shifts every pixel of the sweep, so the first columns checked already show it.

// File: rtl/lbuf_pkg.sv
`timescale 1ns/1ps
// Package: shared half-selection rules for the pixel line buffer.
// Assumes the display row parity is a single bit that changes only
// between scan lines.
package lbuf_pkg;

    // Half currently scanned out for a given display row parity.
    function automatic logic shown_half(input logic row_odd);
        return row_odd;
    endfunction

    // Half receiving the next row; always the opposite of the shown half.
    function automatic logic fill_half(input logic row_odd);
        return ~row_odd;
    endfunction

endpackage

// File: rtl/lbuf_wr_addr.sv
`timescale 1ns/1ps
// Module: write column tracker and write address former.
// Keeps the byte column of the next incoming word, loads it at burst
// start and steps it by one word per accepted beat. Assumes burst_load
// and beats come from the system clock domain.
module lbuf_wr_addr
    import lbuf_pkg::*;
#(
    parameter int COL_W     = 12,
    parameter int COL_IDX_W = 11,
    parameter int LANE_W    = 2,
    parameter int WADDR_W   = 10
) (
    input  logic               sys_clk,
    input  logic               sys_rst_n,
    input  logic               bus_active,
    input  logic               bus_ack,
    input  logic               burst_load,
    input  logic [COL_W-1:0]   burst_col,
    input  logic               row_odd,
    output logic               wr_en,
    output logic [WADDR_W-1:0] wr_addr,
    output logic [COL_W-1:0]   fetch_col
);

    localparam logic [COL_W-1:0] STEP = COL_W'(1 << LANE_W);

    logic beat;

    // Accepted beat: bus cycle active and memory acknowledging.
    assign beat  = bus_active & bus_ack;
    assign wr_en = beat;

    // Column register: load wins, otherwise advance one word per beat.
    always_ff @(posedge sys_clk) begin
        if (!sys_rst_n) begin
            fetch_col <= '0;
        end else if (burst_load) begin
            fetch_col <= burst_col;
        end else if (beat) begin
            fetch_col <= fetch_col + STEP;
        end
    end

    // Word address: fill half on top, word index from column bits.
    assign wr_addr = {fill_half(row_odd), fetch_col[COL_IDX_W-1:LANE_W]};

endmodule

// File: rtl/lbuf_rd_addr.sv
`timescale 1ns/1ps
// Module: read address former.
// Maps display row parity and pixel column to a byte address, with the
// lane bits inverted so the leftmost pixel comes from the top byte.
// Purely combinational; assumes pix_col is already in the video domain.
module lbuf_rd_addr
    import lbuf_pkg::*;
#(
    parameter int COL_W     = 12,
    parameter int COL_IDX_W = 11,
    parameter int LANE_W    = 2,
    parameter int BADDR_W   = 12
) (
    input  logic               row_odd,
    input  logic [COL_W-1:0]   pix_col,
    output logic [BADDR_W-1:0] rd_addr
);

    // Byte address: shown half, word index, reversed lane.
    assign rd_addr = {shown_half(row_odd),
                      pix_col[COL_IDX_W-1:LANE_W],
                      ~pix_col[LANE_W-1:0]};

endmodule

// File: rtl/lbuf_store.sv
`timescale 1ns/1ps
// Module: mixed-width dual-clock storage.
// One byte-wide memory per lane, written a whole word at a time on
// sys_clk and read one byte at a time on vid_clk with one cycle of
// registered latency. There is no guard against the two ports touching
// the same word; the caller keeps them in opposite halves.
module lbuf_store #(
    parameter int PIX_W   = 8,
    parameter int LANES   = 4,
    parameter int LANE_W  = 2,
    parameter int WADDR_W = 10,
    parameter int BADDR_W = 12
) (
    input  logic                     sys_clk,
    input  logic                     wr_en,
    input  logic [WADDR_W-1:0]       wr_addr,
    input  logic [LANES*PIX_W-1:0]   wr_data,
    input  logic                     vid_clk,
    input  logic                     vid_rst_n,
    input  logic [BADDR_W-1:0]       rd_addr,
    output logic [PIX_W-1:0]         rd_pix
);

    localparam int DEPTH = 1 << WADDR_W;

    logic [WADDR_W-1:0]     rd_word;
    logic [LANES*PIX_W-1:0] lanes_q;
    logic [LANE_W-1:0]      sel_q;

    assign rd_word = rd_addr[BADDR_W-1:LANE_W];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [PIX_W-1:0] mem [DEPTH];
        logic [PIX_W-1:0] q;

        // Lane write: store this lane's byte of the incoming word.
        always_ff @(posedge sys_clk) begin
            if (wr_en) begin
                mem[wr_addr] <= wr_data[g*PIX_W +: PIX_W];
            end
        end

        // Lane read: synchronous read on the video clock.
        always_ff @(posedge vid_clk) begin
            if (!vid_rst_n) begin
                q <= '0;
            end else begin
                q <= mem[rd_word];
            end
        end

        assign lanes_q[g*PIX_W +: PIX_W] = q;
    end

    // Lane select register, aligned with the lane read data.
    always_ff @(posedge vid_clk) begin
        if (!vid_rst_n) begin
            sel_q <= '0;
        end else begin
            sel_q <= rd_addr[LANE_W-1:0];
        end
    end

    assign rd_pix = lanes_q[int'(sel_q)*PIX_W +: PIX_W];

endmodule

// File: rtl/pixel_line_buffer.sv
`timescale 1ns/1ps
// Module: dual-clock ping-pong pixel line buffer (top).
// Words from the burst fetcher are written on sys_clk into the half not
// shown; pixels are read on vid_clk from the half chosen by row parity
// and registered once more before the output. Assumes row_odd changes
// only between scan lines, away from write and read activity.
module pixel_line_buffer #(
    parameter int PIX_W     = 8,
    parameter int WORD_W    = 32,
    parameter int COL_W     = 12,
    parameter int COL_IDX_W = 11
) (
    input  logic              sys_clk,
    input  logic              sys_rst_n,
    input  logic              bus_active,
    input  logic              bus_ack,
    input  logic              burst_load,
    input  logic [COL_W-1:0]  burst_col,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              row_odd,
    input  logic              vid_clk,
    input  logic              vid_rst_n,
    input  logic [COL_W-1:0]  pix_col,
    output logic [PIX_W-1:0]  pix_out
);

    localparam int LANES   = WORD_W / PIX_W;
    localparam int LANE_W  = $clog2(LANES);
    localparam int WADDR_W = COL_IDX_W - LANE_W + 1;
    localparam int BADDR_W = COL_IDX_W + 1;

    logic               wr_en;
    logic [WADDR_W-1:0] wr_addr;
    logic [COL_W-1:0]   fetch_col;
    logic [BADDR_W-1:0] rd_addr;
    logic [PIX_W-1:0]   rd_pix;

    lbuf_wr_addr #(
        .COL_W(COL_W), .COL_IDX_W(COL_IDX_W),
        .LANE_W(LANE_W), .WADDR_W(WADDR_W)
    ) u_wr (
        .sys_clk(sys_clk), .sys_rst_n(sys_rst_n),
        .bus_active(bus_active), .bus_ack(bus_ack),
        .burst_load(burst_load), .burst_col(burst_col),
        .row_odd(row_odd),
        .wr_en(wr_en), .wr_addr(wr_addr), .fetch_col(fetch_col)
    );

    lbuf_rd_addr #(
        .COL_W(COL_W), .COL_IDX_W(COL_IDX_W),
        .LANE_W(LANE_W), .BADDR_W(BADDR_W)
    ) u_rd (
        .row_odd(row_odd), .pix_col(pix_col), .rd_addr(rd_addr)
    );

    lbuf_store #(
        .PIX_W(PIX_W), .LANES(LANES), .LANE_W(LANE_W),
        .WADDR_W(WADDR_W), .BADDR_W(BADDR_W)
    ) u_mem (
        .sys_clk(sys_clk), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data),
        .vid_clk(vid_clk), .vid_rst_n(vid_rst_n),
        .rd_addr(rd_addr), .rd_pix(rd_pix)
    );

    // Output register: second video-clock stage ahead of the pixel port.
    always_ff @(posedge vid_clk) begin
        if (!vid_rst_n) begin
            pix_out <= '0;
        end else begin
            pix_out <= rd_pix;
        end
    end

endmodule

// File: rtl/lbuf_checker.sv
`timescale 1ns/1ps
// Module: assertion checker for pixel_line_buffer, attached by bind.
// Observes the top ports together with the write column, write address
// and read address driven by the separate address modules.
module lbuf_checker #(
    parameter int PIX_W   = 8,
    parameter int COL_W   = 12,
    parameter int LANES   = 4,
    parameter int WADDR_W = 10,
    parameter int BADDR_W = 12
) (
    input logic               sys_clk,
    input logic               sys_rst_n,
    input logic               bus_active,
    input logic               bus_ack,
    input logic               burst_load,
    input logic [COL_W-1:0]   burst_col,
    input logic               vid_clk,
    input logic               vid_rst_n,
    input logic [PIX_W-1:0]   pix_out,
    input logic               wr_en,
    input logic [WADDR_W-1:0] wr_addr,
    input logic [BADDR_W-1:0] rd_addr,
    input logic [COL_W-1:0]   fetch_col
);

    AST_LOAD_TAKES: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        burst_load |=> fetch_col == $past(burst_col)); // R2

    AST_BEAT_STEPS: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        (bus_active && bus_ack && !burst_load)
        |=> fetch_col == $past(fetch_col) + COL_W'(LANES)); // R2

    AST_IDLE_HOLDS: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        (!(bus_active && bus_ack) && !burst_load) |=> $stable(fetch_col)); // R8

    AST_HALVES_APART: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        wr_en |-> wr_addr[WADDR_W-1] != rd_addr[BADDR_W-1]); // R3

    AST_PIX_RESET: assert property (@(posedge vid_clk)
        !vid_rst_n |=> pix_out == '0); // R7

    AST_COL_RESET: assert property (@(posedge sys_clk)
        !sys_rst_n |=> fetch_col == '0); // R7

endmodule

bind pixel_line_buffer lbuf_checker #(
    .PIX_W(PIX_W), .COL_W(COL_W), .LANES(LANES),
    .WADDR_W(WADDR_W), .BADDR_W(BADDR_W)
) u_chk (
    .sys_clk(sys_clk), .sys_rst_n(sys_rst_n),
    .bus_active(bus_active), .bus_ack(bus_ack),
    .burst_load(burst_load), .burst_col(burst_col),
    .vid_clk(vid_clk), .vid_rst_n(vid_rst_n), .pix_out(pix_out),
    .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr),
    .fetch_col(fetch_col)
);

// File: tb/tb_pixel_line_buffer.sv
`timescale 1ns/1ps
// Bench: fills both halves with computed patterns (with stall beats),
// sweeps every column of each half on an unrelated video clock and
// compares against a model built from the requirements.
module tb_pixel_line_buffer;

    logic        sys_clk = 1'b0;
    logic        vid_clk = 1'b0;
    logic        sys_rst_n, vid_rst_n;
    logic        bus_active, bus_ack, burst_load, row_odd;
    logic [11:0] burst_col, pix_col;
    logic [31:0] wr_data;
    logic [7:0]  pix_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [31:0] model [2][512];

    always #4    sys_clk = ~sys_clk;   // 125 MHz
    always #5.5  vid_clk = ~vid_clk;   // unrelated video clock

    pixel_line_buffer dut (
        .sys_clk(sys_clk), .sys_rst_n(sys_rst_n),
        .bus_active(bus_active), .bus_ack(bus_ack),
        .burst_load(burst_load), .burst_col(burst_col),
        .wr_data(wr_data), .row_odd(row_odd),
        .vid_clk(vid_clk), .vid_rst_n(vid_rst_n),
        .pix_col(pix_col), .pix_out(pix_out)
    );

    function automatic logic [31:0] pat(input int seed, input int w);
        return (32'(w + 1) * 32'h9E37_79B1) ^ 32'(seed);
    endfunction

    // R4: column c -> word c[10:2], lane 3 - c[1:0]
    function automatic logic [7:0] exp_pix(input int h, input logic [11:0] c);
        logic [31:0] w;
        w = model[h][c[10:2]];
        return w[(3 - int'(c[1:0]))*8 +: 8];
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic sys_cycle(input logic act, input logic ack, input logic ld,
                             input logic [11:0] col, input logic [31:0] d);
        @(negedge sys_clk);
        bus_active = act; bus_ack = ack; burst_load = ld;
        burst_col = col; wr_data = d;
    endtask

    // Accepted beat, with an occasional pair of non-accepted cycles (R8).
    task automatic beat(input int w, input logic [31:0] d);
        if (w % 37 == 5) begin
            sys_cycle(1'b1, 1'b0, 1'b0, 12'h0, 32'hDEAD_BEEF);
            sys_cycle(1'b0, 1'b1, 1'b0, 12'h0, 32'hBADC_0FFE);
        end
        sys_cycle(1'b1, 1'b1, 1'b0, 12'h0, d);
    endtask

    // Sweep all columns of the shown half; output lags the column by 2.
    task automatic sweep(input logic row, input logic [11:0] hi, input string req);
        logic [11:0] c1, c2;
        int h;
        h = row ? 1 : 0;
        c1 = '0; c2 = '0;
        @(negedge vid_clk);
        row_odd = row;
        for (int i = 0; i < 2050; i++) begin
            @(negedge vid_clk);
            if (i >= 2) begin
                check(pix_out == exp_pix(h, c2), req, 32'(pix_out),
                      32'(exp_pix(h, c2)));
            end
            c2 = c1;
            c1 = (i < 2048) ? (12'(i) | hi) : hi;
            pix_col = c1;
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        sys_rst_n = 1'b0; vid_rst_n = 1'b0;
        bus_active = 1'b0; bus_ack = 1'b0; burst_load = 1'b0;
        burst_col = '0; wr_data = '0; row_odd = 1'b1; pix_col = '0;
        repeat (4) @(negedge vid_clk);
        check(pix_out == 8'h00, "R7 reset output", 32'(pix_out), 32'h0);
        @(negedge sys_clk); sys_rst_n = 1'b1;
        @(negedge vid_clk); vid_rst_n = 1'b1;

        // R7/R1: no load after reset -> column starts at 0; fill half 0.
        sys_cycle(1'b0, 1'b0, 1'b0, 12'h0, 32'h0);
        row_odd = 1'b1;
        for (int w = 0; w < 512; w++) begin
            beat(w, pat(32'h1111, w));
            model[0][w] = pat(32'h1111, w);
        end
        sys_cycle(1'b0, 1'b0, 1'b0, 12'h0, 32'h0);

        // R2/R3: row_odd=0 fills half 1, second part of line first.
        row_odd = 1'b0;
        sys_cycle(1'b0, 1'b0, 1'b1, 12'd1024, 32'h0);
        for (int w = 256; w < 512; w++) begin
            beat(w, pat(32'h2222, w));
            model[1][w] = pat(32'h2222, w);
        end
        sys_cycle(1'b0, 1'b0, 1'b1, 12'd0, 32'h0);
        for (int w = 0; w < 256; w++) begin
            beat(w, pat(32'h2222, w));
            model[1][w] = pat(32'h2222, w);
        end
        sys_cycle(1'b0, 1'b0, 1'b0, 12'h0, 32'h0);

        // R5: burst start column with bit 11 set lands at word 16 of half 0.
        row_odd = 1'b1;
        sys_cycle(1'b0, 1'b0, 1'b1, 12'h800 | 12'd64, 32'h0);
        for (int k = 0; k < 4; k++) begin
            sys_cycle(1'b1, 1'b1, 1'b0, 12'h0, pat(32'h3333, k));
            model[0][16 + k] = pat(32'h3333, k);
        end
        sys_cycle(1'b0, 1'b0, 1'b0, 12'h0, 32'h0);
        repeat (3) @(negedge sys_clk);

        sweep(1'b1, 12'h000, "R1 R2 R4 R8 half 1 contents");
        sweep(1'b0, 12'h800, "R3 R5 half 0 untouched, high column bit ignored");

        // R6: latency of exactly two video clocks.
        @(negedge vid_clk); row_odd = 1'b1; pix_col = 12'd0;
        repeat (3) @(negedge vid_clk);
        pix_col = 12'd5;
        @(negedge vid_clk);
        check(pix_out == exp_pix(1, 12'd0), "R6 one cycle after change",
              32'(pix_out), 32'(exp_pix(1, 12'd0)));
        @(negedge vid_clk);
        check(pix_out == exp_pix(1, 12'd5), "R6 two cycles after change",
              32'(pix_out), 32'(exp_pix(1, 12'd5)));

        // R7: synchronous reset of the output mid-operation.
        vid_rst_n = 1'b0;
        @(negedge vid_clk);
        check(pix_out == 8'h00, "R7 reset during display", 32'(pix_out), 32'h0);
        vid_rst_n = 1'b1;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule